// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one channel of a general-purpose timer. It compares a counter value, supplied from outside, with a compare value held inside. From that comparison it produces a single reference waveform. Eight modes set what a comparison does to the output: hold, set high, set low, toggle, force low, force high, or one of two pulse-width modulation shapes.

The compare value can be written straight into the active register. It can also be staged in a shadow copy that moves across only on an update pulse. An external clear input can hold the output low, and it is honoured only when enabled. A fast trigger path lets a rising trigger edge drive the PWM output to its compare level after a short fixed latency, without waiting for the counter.

Configuration fields are written together through one strobe. The output is registered: it reflects the counter value seen at the previous rising clock edge.

Top module: `timer_oc_channel`

## Requirements
- R1: While `rst_ni` is low, `ref_o` is 0. Reset leaves the configuration as follows: mode 0 (frozen), preload off, fast off, clear-enable off, direction 0. It also sets both compare registers to 0.
- R2: A configuration write with `cfg_we_i` high is registered at that clock edge. Mode 5 drives `ref_o` to 1 and mode 4 drives it to 0. In both cases the new level appears after the second rising edge counted from the write edge, whatever the counter does.
- R3: Mode 6: after each edge, `ref_o` is 1 when the counter sampled at that edge is below the active compare value, and 0 otherwise. Mode 7 gives the inverse.
- R4: Mode 1 drives `ref_o` to 1 on the edge where the counter equals the active compare value. Mode 2 drives it to 0 on that edge. Otherwise both modes hold the output.
- R5: Mode 3 inverts `ref_o` at every edge where the counter equals the active compare value, and holds it otherwise.
- R6: Mode 0 keeps `ref_o` at the level it had when the mode was entered, regardless of the counter.
- R7: With preload off, a compare write becomes the active compare value at the write edge.
- R8: With preload on, a compare write goes only to the shadow register. The shadow is copied to the active register at each edge where `update_i` is high. If a write and an update share an edge, the active register takes the old shadow value and the written value stays in the shadow.
- R9: With clear-enable set, `clr_i` high forces `ref_o` to 0 in the same cycle, for as long as `clr_i` stays high. With clear-enable off, `clr_i` has no effect.
- R10: With fast set in mode 6 or 7, a rising edge on `trig_i` drives `ref_o` to its compare level for one cycle: 0 in mode 6, 1 in mode 7. The level appears after the third rising clock edge that samples `trig_i` high, even when the comparison says otherwise.
- R11: The trigger has no effect on `ref_o` when fast is off, or when the mode is not 6 or 7.
- R12: With direction 1, `ref_o` goes to 0 and stays at 0, whatever the mode and counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Counter value from the time base |
| update_i | input | 1 | Update event pulse |
| trig_i | input | 1 | Trigger input, rising edge active |
| clr_i | input | 1 | External clear, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Compare mode code 0..7 |
| cfg_preload_i | input | 1 | Preload enable |
| cfg_fast_i | input | 1 | Fast trigger enable |
| cfg_clr_en_i | input | 1 | External clear enable |
| cfg_dir_i | input | 1 | Channel direction, 1 disables compare output |
| ccr_we_i | input | 1 | Compare value write strobe |
| ccr_i | input | CNT_W | Compare value to write |
| ref_o | output | 1 | Reference output |

## Verification
The bench sweeps every compare value against every counter value in both PWM modes. A wrong comparison operator or a wrong inversion shows up as an output that is off by one count at the threshold.

It checks the edge where preload writes and updates coincide. A design that lets the write pass straight into the active register would move the PWM threshold one update too early.

It counts trigger latency edge by edge and checks that the forced level lasts only one cycle. An off-by-one synchronizer would force the output one edge early or late, and a level-sensitive trigger would hold it forced.

Frozen, toggle and set/clear-on-match runs look for actions taken on cycles with no match. Clear and direction runs check that the output is masked at once and released cleanly.

// File: rtl/timer_oc_pkg.sv
package timer_oc_pkg;

  typedef enum logic [2:0] {
    OC_FROZEN   = 3'd0,
    OC_SET      = 3'd1,
    OC_CLR      = 3'd2,
    OC_TOGGLE   = 3'd3,
    OC_FORCE_LO = 3'd4,
    OC_FORCE_HI = 3'd5,
    OC_PWM1     = 3'd6,
    OC_PWM2     = 3'd7
  } oc_mode_e;

  typedef struct packed {
    oc_mode_e mode;
    logic     preload;
    logic     fast;
    logic     clr_en;
    logic     dir;
  } oc_cfg_t;

endpackage

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
  import timer_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  oc_cfg_t          cfg_i,
  input  logic             ccr_we_i,
  input  logic [CNT_W-1:0] ccr_i,
  input  logic             update_i,
  output oc_cfg_t          cfg_o,
  output logic [CNT_W-1:0] ccr_act_o
);

  oc_cfg_t          cfg_q;
  logic [CNT_W-1:0] ccr_shadow_q, ccr_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q <= cfg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_shadow_q <= '0;
      ccr_act_q    <= '0;
    end else begin
      if (ccr_we_i) ccr_shadow_q <= ccr_i;
      if (!cfg_q.preload) begin
        if (ccr_we_i) ccr_act_q <= ccr_i;
      end else if (update_i) begin
        // old shadow wins over a same-edge write
        ccr_act_q <= ccr_shadow_q;
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign ccr_act_o = ccr_act_q;

  assert_direct_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.preload && ccr_we_i) |=> (ccr_act_o == $past(ccr_i)));

  assert_preload_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.preload && !update_i) |=> $stable(ccr_act_o));

endmodule

// File: rtl/oc_trig_edge.sv
module oc_trig_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);

  localparam int LastIdx = SYNC_STAGES;

  logic [LastIdx:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LastIdx-1:0], trig_i};
  end

  assign edge_o = sh_q[LastIdx-1] & ~sh_q[LastIdx];

  assert_edge_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import timer_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  oc_mode_e         mode_i,
  input  logic             fast_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ccr_i,
  input  logic             trig_edge_i,
  output logic             ref_o
);

  logic ref_q, ref_d;
  logic match, below, is_pwm, fast_hit;

  assign match    = (cnt_i == ccr_i);
  assign below    = (cnt_i < ccr_i);
  assign is_pwm   = (mode_i == OC_PWM1) || (mode_i == OC_PWM2);
  assign fast_hit = trig_edge_i && fast_i && is_pwm;

  always_comb begin
    ref_d = ref_q;
    if (dir_i) begin
      ref_d = 1'b0;
    end else begin
      case (mode_i)
        OC_FROZEN:   ref_d = ref_q;
        OC_SET:      if (match) ref_d = 1'b1;
        OC_CLR:      if (match) ref_d = 1'b0;
        OC_TOGGLE:   if (match) ref_d = ~ref_q;
        OC_FORCE_LO: ref_d = 1'b0;
        OC_FORCE_HI: ref_d = 1'b1;
        OC_PWM1:     ref_d = fast_hit ? 1'b0 : below;
        OC_PWM2:     ref_d = fast_hit ? 1'b1 : ~below;
        default:     ref_d = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_d;
  end

  assign ref_o = ref_q;

  assert_force_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_FORCE_HI && !dir_i) |=> ref_q);

  assert_frozen_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_FROZEN && !dir_i) |=> (ref_q == $past(ref_q)));

  assert_pwm1_below_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OC_PWM1 && !dir_i && !trig_edge_i && (cnt_i < ccr_i)) |=> ref_q);

  assert_fast_pwm1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_edge_i && fast_i && mode_i == OC_PWM1 && !dir_i) |=> !ref_q);

  assert_dir_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_i |=> !ref_q);

endmodule

// File: rtl/timer_oc_channel.sv
module timer_oc_channel
  import timer_oc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             update_i,
  input  logic             trig_i,
  input  logic             clr_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             cfg_preload_i,
  input  logic             cfg_fast_i,
  input  logic             cfg_clr_en_i,
  input  logic             cfg_dir_i,
  input  logic             ccr_we_i,
  input  logic [CNT_W-1:0] ccr_i,
  output logic             ref_o
);

  oc_cfg_t          cfg_in, cfg;
  logic [CNT_W-1:0] ccr_act;
  logic             trig_edge, ref_raw;

  assign cfg_in.mode    = oc_mode_e'(cfg_mode_i);
  assign cfg_in.preload = cfg_preload_i;
  assign cfg_in.fast    = cfg_fast_i;
  assign cfg_in.clr_en  = cfg_clr_en_i;
  assign cfg_in.dir     = cfg_dir_i;

  oc_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_we_i),
    .cfg_i     (cfg_in),
    .ccr_we_i  (ccr_we_i),
    .ccr_i     (ccr_i),
    .update_i  (update_i),
    .cfg_o     (cfg),
    .ccr_act_o (ccr_act)
  );

  oc_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .edge_o (trig_edge)
  );

  oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (cfg.mode),
    .fast_i      (cfg.fast),
    .dir_i       (cfg.dir),
    .cnt_i       (cnt_i),
    .ccr_i       (ccr_act),
    .trig_edge_i (trig_edge),
    .ref_o       (ref_raw)
  );

  // level-sensitive clear, no register in the path
  assign ref_o = ref_raw & ~(cfg.clr_en & clr_i);

endmodule

// File: tb/tb_timer_oc_channel.sv
module tb_timer_oc_channel;

  localparam int CW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic          update_i = 1'b0, trig_i = 1'b0, clr_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_mode_i = '0;
  logic          cfg_preload_i = 1'b0, cfg_fast_i = 1'b0;
  logic          cfg_clr_en_i = 1'b0, cfg_dir_i = 1'b0;
  logic          ccr_we_i = 1'b0;
  logic [CW-1:0] ccr_i = '0;
  logic          ref_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  timer_oc_channel #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
    .clk_i, .rst_ni, .cnt_i, .update_i, .trig_i, .clr_i,
    .cfg_we_i, .cfg_mode_i, .cfg_preload_i, .cfg_fast_i, .cfg_clr_en_i,
    .cfg_dir_i, .ccr_we_i, .ccr_i, .ref_o
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input logic exp, input string tag);
    n_run++;
    if (ref_o !== exp) begin
      n_fail++;
      $display("FAIL %s: ref_o=%b expected %b at %0t", tag, ref_o, exp, $time);
    end
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic pre, input logic fa,
                         input logic ce, input logic dr);
    cfg_we_i = 1'b1; cfg_mode_i = m; cfg_preload_i = pre;
    cfg_fast_i = fa; cfg_clr_en_i = ce; cfg_dir_i = dr;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic wr_ccr(input logic [CW-1:0] v);
    ccr_we_i = 1'b1; ccr_i = v;
    tick();
    ccr_we_i = 1'b0;
  endtask

  // PWM1 threshold probe: below -> 1, at -> 0
  task automatic threshold(input int t, input string tag);
    cnt_i = CW'(t - 1); tick(); chk(1'b1, tag);
    cnt_i = CW'(t);     tick(); chk(1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic e;
    repeat (3) @(posedge clk_i);
    #1;
    chk(1'b0, "R1 in reset");
    rst_ni = 1'b1;
    tick(); chk(1'b0, "R1 frozen after reset");

    // R2 force modes
    set_cfg(3'd5, 0, 0, 0, 0); chk(1'b0, "R2 not yet");
    tick(); chk(1'b1, "R2 force high");
    for (int c = 0; c < 8; c++) begin cnt_i = CW'(c * 3); tick(); chk(1'b1, "R2 hold high"); end
    set_cfg(3'd4, 0, 0, 0, 0); chk(1'b1, "R2 not yet low");
    tick(); chk(1'b0, "R2 force low");

    // R3 PWM sweeps
    for (int m = 6; m < 8; m++) begin
      set_cfg(3'(m), 0, 0, 0, 0);
      for (int cc = 0; cc < 16; cc++) begin
        wr_ccr(CW'(cc));
        for (int c = 0; c < 16; c++) begin
          cnt_i = CW'(c); tick();
          chk(((c < cc) ? 1'b1 : 1'b0) ^ (m == 7), "R3 pwm sweep");
        end
      end
    end

    // R4 set on match
    set_cfg(3'd4, 0, 0, 0, 0); cnt_i = 9; tick();
    wr_ccr(5);
    set_cfg(3'd1, 0, 0, 0, 0);
    for (int c = 0; c < 10; c++) begin cnt_i = CW'(c); tick(); chk(c >= 5, "R4 set on match"); end
    // R4 clear on match
    set_cfg(3'd5, 0, 0, 0, 0); tick();
    set_cfg(3'd2, 0, 0, 0, 0);
    for (int c = 0; c < 10; c++) begin cnt_i = CW'(c); tick(); chk(c < 5, "R4 clear on match"); end

    // R5 toggle
    set_cfg(3'd4, 0, 0, 0, 0); tick();
    wr_ccr(3);
    set_cfg(3'd3, 0, 0, 0, 0);
    e = 1'b0;
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 8; c++) begin
        cnt_i = CW'(c); tick();
        if (c == 3) e = ~e;
        chk(e, "R5 toggle");
      end

    // R6 frozen keeps high, then low
    set_cfg(3'd5, 0, 0, 0, 0); tick();
    set_cfg(3'd0, 0, 0, 0, 0);
    for (int c = 0; c < 16; c++) begin cnt_i = CW'(c); tick(); chk(1'b1, "R6 frozen high"); end
    set_cfg(3'd4, 0, 0, 0, 0); tick();
    set_cfg(3'd0, 0, 0, 0, 0);
    for (int c = 0; c < 16; c++) begin cnt_i = CW'(c); tick(); chk(1'b0, "R6 frozen low"); end

    // R7 direct write, R8 preload
    set_cfg(3'd6, 0, 0, 0, 0);
    wr_ccr(4); threshold(4, "R7 direct write");
    set_cfg(3'd6, 1, 0, 0, 0);
    wr_ccr(9); threshold(4, "R8 shadow only");
    update_i = 1'b1; tick(); update_i = 1'b0;
    threshold(9, "R8 after update");
    wr_ccr(11);
    ccr_we_i = 1'b1; ccr_i = 13; update_i = 1'b1; tick();
    ccr_we_i = 1'b0; update_i = 1'b0;
    threshold(11, "R8 same-edge old shadow");
    update_i = 1'b1; tick(); update_i = 1'b0;
    threshold(13, "R8 second update");

    // R9 clear
    set_cfg(3'd5, 0, 0, 1, 0); tick(); chk(1'b1, "R9 pre");
    clr_i = 1'b1; #1; chk(1'b0, "R9 clear same cycle");
    tick(); chk(1'b0, "R9 clear held");
    clr_i = 1'b0; #1; chk(1'b1, "R9 release");
    set_cfg(3'd5, 0, 0, 0, 0);
    clr_i = 1'b1; #1; chk(1'b1, "R9 clear ignored");
    tick(); chk(1'b1, "R9 clear ignored");
    clr_i = 1'b0;

    // R10 fast PWM1
    set_cfg(3'd6, 0, 1, 0, 0); wr_ccr(10); cnt_i = 0;
    tick(); chk(1'b1, "R10 pwm1 base");
    trig_i = 1'b1;
    tick(); chk(1'b1, "R10 edge1");
    tick(); chk(1'b1, "R10 edge2");
    tick(); chk(1'b0, "R10 edge3 forced");
    tick(); chk(1'b1, "R10 one cycle only");
    trig_i = 1'b0; repeat (4) tick();
    // R10 fast PWM2
    set_cfg(3'd7, 0, 1, 0, 0);
    tick(); chk(1'b0, "R10 pwm2 base");
    trig_i = 1'b1;
    tick(); chk(1'b0, "R10 pwm2 edge1");
    tick(); chk(1'b0, "R10 pwm2 edge2");
    tick(); chk(1'b1, "R10 pwm2 forced");
    tick(); chk(1'b0, "R10 pwm2 one cycle");
    trig_i = 1'b0; repeat (4) tick();

    // R11 no fast effect
    set_cfg(3'd6, 0, 0, 0, 0); tick(); chk(1'b1, "R11 base");
    trig_i = 1'b1;
    for (int k = 0; k < 5; k++) begin tick(); chk(1'b1, "R11 fast off"); end
    trig_i = 1'b0; repeat (4) tick();
    set_cfg(3'd4, 0, 0, 0, 0); tick();
    set_cfg(3'd1, 0, 1, 0, 0);
    trig_i = 1'b1;
    for (int k = 0; k < 5; k++) begin tick(); chk(1'b0, "R11 non-pwm mode"); end
    trig_i = 1'b0; repeat (4) tick();

    // R12 direction
    set_cfg(3'd5, 0, 0, 0, 1); tick(); tick(); chk(1'b0, "R12 dir low");
    for (int c = 0; c < 12; c++) begin cnt_i = CW'(c); tick(); chk(1'b0, "R12 dir held"); end
    set_cfg(3'd5, 0, 0, 0, 0); tick(); chk(1'b1, "R12 released");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule